// File: doc/BRIEF.md
# Multi-Bin Bypass Packet Encoder

This block sits at the front of a binary arithmetic encoder. It lets the encoder take in several equiprobable (bypass) bins in one cycle. A stream of bins arrives one bin per cycle, and each bin is tagged with a 2-bit kind. Bypass bins that arrive back to back are collected into a group of up to four. Each context-coded (regular) bin and each end-of-slice (terminate) bin leaves at once as a single-bin packet, on a side port that feeds the neighbouring interval engine. Each of these bins also closes any group that is still open.

A closed bypass group becomes a packet. The packet holds its length and its bin values as one number, with the first bin in the most significant position. The packet then passes through three more stages:
- The bin value is scaled by the current interval width, using only shifted copies of the width and additions.
- The low register is moved on by the whole group in one step.
- The bits that leave the top of the low register are sent out with a count of how many new bit positions they cover.

The interval width comes from the neighbouring engine on an input port. This block never changes it.

Top module: `mbp_encoder`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `sb_valid` and `out_valid` are low. The low register starts at zero.
- R2: A bypass bin that makes an open group four bins long closes that group on the same clock edge. The group result appears on `out_valid` four cycles after that bin was presented.
- R3: A bin of kind 2'b00 (regular) or 2'b10 (terminate) appears on the single-bin port one cycle after it is presented. Its kind, value and context index are unchanged. On the same edge it closes any open bypass group, and that group's result follows the R2 latency.
- R4: `in_eos` closes any open group, whether `in_valid` is high or not. A bypass bin presented in the same cycle joins the group before the group closes.
- R5: A bin of kind 2'b11 is ignored. It does not produce a single-bin packet, it does not close a group and it does not join one.
- R6: A bypass packet holds 1 to 4 bins. `out_cnt` equals the number of bins in the group.
- R7: For a group of n bins whose values, read with the first bin as the most significant bit, form v, and for a width r on `rng_i`: let s = (low << n) + v*r. The new low is s mod 1024 and `out_bits` is s >> 10.
- R8: Regular, terminate and ignored bins leave the low register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A bin is presented this cycle |
| in_mode | input | 2 | Bin kind: 00 regular, 01 bypass, 10 terminate, 11 ignored |
| in_bin | input | 1 | Bin value |
| in_ctx | input | 6 | Context index carried by regular bins |
| in_eos | input | 1 | End of slice: close the open group |
| rng_i | input | 9 | Interval width from the interval engine |
| sb_valid | output | 1 | Single-bin packet valid |
| sb_mode | output | 2 | Kind of the single-bin packet |
| sb_bin | output | 1 | Value of the single-bin packet |
| sb_ctx | output | 6 | Context index of the single-bin packet |
| out_valid | output | 1 | Bypass result valid |
| out_bits | output | 5 | Bits leaving the top of low, right-aligned, including a possible carry |
| out_cnt | output | 3 | New bit positions covered by out_bits |

## Verification
The assertions assume that `rng_i` lies between 256 and 510 and does not change while a group is in flight. They also assume that the bin kind is meaningful only while `in_valid` is high. The stimulus changes the width only after a quiet gap of several idle cycles, long enough for the pipeline to drain. Between those gaps, random runs mix all four bin kinds, end-of-slice pulses and idle cycles. Directed sequences cover a full group, a group closed by a regular bin, a group closed by a terminate bin, end of slice with and without a bin, and an ignored bin placed inside a group.

// File: rtl/mbp_pkg.sv
package mbp_pkg;
  typedef enum logic [1:0] {
    KIND_REG  = 2'b00,
    KIND_BYP  = 2'b01,
    KIND_TERM = 2'b10,
    KIND_RSV  = 2'b11
  } bin_kind_e;
endpackage

// File: rtl/mbp_packer.sv
module mbp_packer #(
  parameter int MAXN  = 4,
  parameter int CTX_W = 6,
  localparam int LEN_W = $clog2(MAXN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       in_mode,
  input  logic             in_bin,
  input  logic [CTX_W-1:0] in_ctx,
  input  logic             in_eos,
  output logic             bp_valid,
  output logic [LEN_W-1:0] bp_len,
  output logic [MAXN-1:0]  bp_bits,
  output logic             sb_valid,
  output logic [1:0]       sb_mode,
  output logic             sb_bin,
  output logic [CTX_W-1:0] sb_ctx
);
  import mbp_pkg::*;

  logic [LEN_W-1:0] grp_len, nxt_len, app_len, emit_len;
  logic [MAXN-1:0]  grp_bits, nxt_bits, app_bits, emit_bits;
  logic             take_bp, take_sb, emit;

  assign take_bp  = in_valid && (in_mode == KIND_BYP);
  assign take_sb  = in_valid && (in_mode == KIND_REG || in_mode == KIND_TERM);
  assign app_len  = grp_len + LEN_W'(1);
  assign app_bits = {grp_bits[MAXN-2:0], in_bin};

  always_comb begin
    nxt_len   = grp_len;
    nxt_bits  = grp_bits;
    emit      = 1'b0;
    emit_len  = '0;
    emit_bits = '0;
    if (take_bp) begin
      if (app_len == LEN_W'(MAXN) || in_eos) begin
        emit      = 1'b1;
        emit_len  = app_len;
        emit_bits = app_bits;
        nxt_len   = '0;
        nxt_bits  = '0;
      end else begin
        nxt_len  = app_len;
        nxt_bits = app_bits;
      end
    end else if ((take_sb || in_eos) && grp_len != '0) begin
      emit      = 1'b1;
      emit_len  = grp_len;
      emit_bits = grp_bits;
      nxt_len   = '0;
      nxt_bits  = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grp_len  <= '0;
      grp_bits <= '0;
      bp_valid <= 1'b0;
      bp_len   <= '0;
      bp_bits  <= '0;
      sb_valid <= 1'b0;
      sb_mode  <= '0;
      sb_bin   <= 1'b0;
      sb_ctx   <= '0;
    end else begin
      grp_len  <= nxt_len;
      grp_bits <= nxt_bits;
      bp_valid <= emit;
      bp_len   <= emit_len;
      bp_bits  <= emit_bits;
      sb_valid <= take_sb;
      if (take_sb) begin
        sb_mode <= in_mode;
        sb_bin  <= in_bin;
        sb_ctx  <= in_ctx;
      end
    end
  end

  AST_FULL_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (take_bp && grp_len == LEN_W'(MAXN - 1)) |=> (bp_valid && bp_len == LEN_W'(MAXN))); // R2
  AST_SB_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    take_sb |=> (sb_valid && sb_mode != KIND_BYP && sb_mode != KIND_RSV)); // R3
  AST_EOS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    in_eos |=> (grp_len == '0)); // R4
  AST_RSV_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == KIND_RSV && !in_eos) |=> ($stable(grp_len) && !sb_valid && !bp_valid)); // R5
  AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    bp_valid |-> (bp_len != '0 && bp_len <= LEN_W'(MAXN))); // R6
endmodule

// File: rtl/mbp_scale.sv
module mbp_scale #(
  parameter int MAXN  = 4,
  parameter int RNG_W = 9,
  localparam int LEN_W  = $clog2(MAXN + 1),
  localparam int PROD_W = RNG_W + MAXN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bp_valid,
  input  logic [LEN_W-1:0]  bp_len,
  input  logic [MAXN-1:0]   bp_bits,
  input  logic [RNG_W-1:0]  rng_i,
  output logic              pr_valid,
  output logic [LEN_W-1:0]  pr_len,
  output logic [PROD_W-1:0] pr_prod
);
  // v * r built from shifted copies of r, one per set bit of v
  function automatic logic [PROD_W-1:0] scale(input logic [MAXN-1:0] v,
                                               input logic [RNG_W-1:0] r);
    logic [PROD_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < MAXN; i++)
      if (v[i]) acc = acc + (PROD_W'(r) << i);
    return acc;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pr_valid <= 1'b0;
      pr_len   <= '0;
      pr_prod  <= '0;
    end else begin
      pr_valid <= bp_valid;
      pr_len   <= bp_len;
      pr_prod  <= bp_valid ? scale(bp_bits, rng_i) : '0;
    end
  end

  AST_STAGE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    bp_valid |=> (pr_valid && pr_len == $past(bp_len))); // R2
endmodule

// File: rtl/mbp_lowout.sv
module mbp_lowout #(
  parameter int MAXN  = 4,
  parameter int RNG_W = 9,
  parameter int LOW_W = 10,
  localparam int LEN_W   = $clog2(MAXN + 1),
  localparam int PROD_W  = RNG_W + MAXN,
  localparam int FULL_W  = LOW_W + MAXN + 1,
  localparam int CHUNK_W = FULL_W - LOW_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pr_valid,
  input  logic [LEN_W-1:0]   pr_len,
  input  logic [PROD_W-1:0]  pr_prod,
  output logic               out_valid,
  output logic [CHUNK_W-1:0] out_bits,
  output logic [LEN_W-1:0]   out_cnt
);
  logic [LOW_W-1:0]   low_q;
  logic [FULL_W-1:0]  step_sum;
  logic               s3_valid;
  logic [CHUNK_W-1:0] s3_chunk;
  logic [LEN_W-1:0]   s3_cnt;

  function automatic logic [FULL_W-1:0] low_step(input logic [LOW_W-1:0] lo,
                                                  input logic [LEN_W-1:0] n,
                                                  input logic [PROD_W-1:0] p);
    return (FULL_W'(lo) << n) + FULL_W'(p);
  endfunction

  assign step_sum = low_step(low_q, pr_len, pr_prod);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_q     <= '0;
      s3_valid  <= 1'b0;
      s3_chunk  <= '0;
      s3_cnt    <= '0;
      out_valid <= 1'b0;
      out_bits  <= '0;
      out_cnt   <= '0;
    end else begin
      s3_valid <= pr_valid;
      if (pr_valid) begin
        low_q    <= step_sum[LOW_W-1:0];
        s3_chunk <= step_sum[FULL_W-1:LOW_W];
        s3_cnt   <= pr_len;
      end
      out_valid <= s3_valid;
      out_bits  <= s3_valid ? s3_chunk : '0;
      out_cnt   <= s3_valid ? s3_cnt : '0;
    end
  end

  AST_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pr_valid |=> $stable(low_q)); // R8
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_cnt != '0 && out_cnt <= LEN_W'(MAXN))); // R6
  AST_OUT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    s3_valid |=> out_valid); // R2
endmodule

// File: rtl/mbp_encoder.sv
module mbp_encoder #(
  parameter int MAXN  = 4,
  parameter int RNG_W = 9,
  parameter int LOW_W = 10,
  parameter int CTX_W = 6,
  localparam int LEN_W   = $clog2(MAXN + 1),
  localparam int PROD_W  = RNG_W + MAXN,
  localparam int CHUNK_W = MAXN + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [1:0]         in_mode,
  input  logic               in_bin,
  input  logic [CTX_W-1:0]   in_ctx,
  input  logic               in_eos,
  input  logic [RNG_W-1:0]   rng_i,
  output logic               sb_valid,
  output logic [1:0]         sb_mode,
  output logic               sb_bin,
  output logic [CTX_W-1:0]   sb_ctx,
  output logic               out_valid,
  output logic [CHUNK_W-1:0] out_bits,
  output logic [LEN_W-1:0]   out_cnt
);
  logic              bp_valid, pr_valid;
  logic [LEN_W-1:0]  bp_len, pr_len;
  logic [MAXN-1:0]   bp_bits;
  logic [PROD_W-1:0] pr_prod;

  mbp_packer #(.MAXN(MAXN), .CTX_W(CTX_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
    .in_bin(in_bin), .in_ctx(in_ctx), .in_eos(in_eos),
    .bp_valid(bp_valid), .bp_len(bp_len), .bp_bits(bp_bits),
    .sb_valid(sb_valid), .sb_mode(sb_mode), .sb_bin(sb_bin), .sb_ctx(sb_ctx));

  mbp_scale #(.MAXN(MAXN), .RNG_W(RNG_W)) u_scale (
    .clk(clk), .rst_n(rst_n), .bp_valid(bp_valid), .bp_len(bp_len),
    .bp_bits(bp_bits), .rng_i(rng_i),
    .pr_valid(pr_valid), .pr_len(pr_len), .pr_prod(pr_prod));

  mbp_lowout #(.MAXN(MAXN), .RNG_W(RNG_W), .LOW_W(LOW_W)) u_low (
    .clk(clk), .rst_n(rst_n), .pr_valid(pr_valid), .pr_len(pr_len),
    .pr_prod(pr_prod), .out_valid(out_valid), .out_bits(out_bits),
    .out_cnt(out_cnt));

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!sb_valid && !out_valid)); // R1
endmodule

// File: tb/mbp_encoder_tb.sv
module mbp_encoder_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [1:0] in_mode = 2'b00;
  logic       in_bin = 1'b0;
  logic [5:0] in_ctx = '0;
  logic       in_eos = 1'b0;
  logic [8:0] rng_i = 9'd256;
  logic       sb_valid, sb_bin;
  logic [1:0] sb_mode;
  logic [5:0] sb_ctx;
  logic       out_valid;
  logic [4:0] out_bits;
  logic [2:0] out_cnt;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  int m_len = 0, m_val = 0, m_low = 0;
  string m_tag = "";
  int    q_due[$], q_bits[$], q_cnt[$];
  string q_tag[$];
  int    s_due[$], s_mode[$], s_bin[$], s_ctx[$];

  mbp_encoder u_dut (.*);

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int ref_sum(int lo, int n, int v, int r);
    return lo * (1 << n) + v * r;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic close_group(string why);
    int s = ref_sum(m_low, m_len, m_val, int'(rng_i));
    q_due.push_back(cyc + 4);
    q_bits.push_back(s >> 10);
    q_cnt.push_back(m_len);
    q_tag.push_back({why, m_tag});
    m_low = s % 1024;
    m_len = 0; m_val = 0; m_tag = "";
  endtask

  // drive one cycle and advance the model
  task automatic send(bit v, logic [1:0] md, bit b, int ctx, bit eos);
    @(negedge clk);
    in_valid = v; in_mode = md; in_bin = b; in_ctx = 6'(ctx); in_eos = eos;
    if (v && md == 2'b11) m_tag = {m_tag, " R5"};
    if (v && md == 2'b01) begin
      m_len++; m_val = m_val * 2 + int'(b);
      if (m_len == 4) close_group("R2");
      else if (eos) close_group("R4");
    end else begin
      if (v && (md == 2'b00 || md == 2'b10)) begin
        if (m_len != 0) close_group("R3");
        s_due.push_back(cyc + 1); s_mode.push_back(md);
        s_bin.push_back(b); s_ctx.push_back(ctx);
        m_tag = {m_tag, " R8"};
      end else if (eos && m_len != 0) close_group("R4");
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) send(0, 2'b00, 0, 0, 0);
  endtask

  // monitor away from the active edge
  always @(negedge clk) if (rst_n) begin
    if (out_valid) begin
      if (q_due.size() == 0) chk(0, "R6 R5 unexpected bypass output", 1, 0);
      else begin
        chk(q_due[0] == cyc, {"R2 latency", q_tag[0]}, cyc, q_due[0]);
        chk(int'(out_cnt) == q_cnt[0], {"R6 count", q_tag[0]}, out_cnt, q_cnt[0]);
        chk(int'(out_bits) == q_bits[0], {"R7 bits", q_tag[0]}, out_bits, q_bits[0]);
        void'(q_due.pop_front()); void'(q_bits.pop_front());
        void'(q_cnt.pop_front()); void'(q_tag.pop_front());
      end
    end else if (q_due.size() != 0 && q_due[0] <= cyc)
      chk(0, {"R2 missing output", q_tag[0]}, 0, 1);
    if (sb_valid) begin
      if (s_due.size() == 0) chk(0, "R5 unexpected single-bin packet", 1, 0);
      else begin
        chk(s_due[0] == cyc && int'(sb_mode) == s_mode[0] && int'(sb_bin) == s_bin[0]
            && int'(sb_ctx) == s_ctx[0], "R3 single-bin packet",
            {sb_mode, sb_bin, sb_ctx}, s_mode[0] * 128 + s_bin[0] * 64 + s_ctx[0]);
        void'(s_due.pop_front()); void'(s_mode.pop_front());
        void'(s_bin.pop_front()); void'(s_ctx.pop_front());
      end
    end else if (s_due.size() != 0 && s_due[0] <= cyc)
      chk(0, "R3 missing single-bin packet", 0, 1);
  end

  always @(posedge clk) if (cyc > 150000 && !done) begin
    done = 1;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!sb_valid && !out_valid, "R1 outputs quiet in reset", {sb_valid, out_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!sb_valid && !out_valid, "R1 outputs quiet after reset", {sb_valid, out_valid}, 0);
    // R7 directed: low 0, range 256, bins 1011
    send(1, 2'b01, 1, 0, 0); send(1, 2'b01, 0, 0, 0);
    send(1, 2'b01, 1, 0, 0); send(1, 2'b01, 1, 0, 0);
    idle(6);
    // R3: two bypass closed by a regular, then by a terminate
    send(1, 2'b01, 1, 0, 0); send(1, 2'b01, 1, 0, 0); send(1, 2'b00, 1, 17, 0);
    send(1, 2'b01, 0, 0, 0); send(1, 2'b10, 1, 0, 0);
    idle(6);
    // R4: eos with no bin, and eos together with a bypass bin
    send(1, 2'b01, 1, 0, 0); send(1, 2'b01, 0, 0, 0); send(1, 2'b01, 1, 0, 0);
    send(0, 2'b00, 0, 0, 1);
    send(1, 2'b01, 1, 0, 0); send(1, 2'b01, 1, 0, 1);
    idle(6);
    // R5: ignored kind inside a group does not close or extend it
    send(1, 2'b01, 1, 0, 0); send(1, 2'b11, 1, 5, 0); send(1, 2'b01, 1, 0, 0);
    send(1, 2'b11, 0, 0, 0); send(1, 2'b01, 1, 0, 0); send(1, 2'b01, 1, 0, 0);
    idle(6);
    rng_i = 9'd510;
    send(1, 2'b01, 1, 0, 0); send(1, 2'b01, 1, 0, 0);
    send(1, 2'b01, 1, 0, 0); send(1, 2'b01, 1, 0, 0);
    idle(6);
    // random runs, range changed only after a drain gap
    void'($urandom(32'd1234));
    for (int blk = 0; blk < 40; blk++) begin
      rng_i = 9'(256 + ($urandom % 255));
      for (int i = 0; i < 150; i++) begin
        int r = $urandom % 16;
        logic [1:0] md = (r < 8) ? 2'b01 : (r < 12) ? 2'b00 : (r < 14) ? 2'b10 : 2'b11;
        send(($urandom % 8) != 0, md, 1'($urandom), int'($urandom % 64), ($urandom % 20) == 0);
      end
      send(0, 2'b00, 0, 0, 1);
      idle(6);
    end
    idle(8);
    chk(q_due.size() == 0 && s_due.size() == 0, "R2 R3 all expected outputs seen",
        q_due.size() + s_due.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule